// File: doc/BRIEF.md
# Time-of-Day Clock with Alarm and Scanned Display

This block keeps the time of day in hours, minutes and seconds and shows it as HH:MM:SS on six seven-segment digits that share one segment bus. A divider turns the system clock into a once-per-second advance. Hours are always counted internally from 0 to 23, and a mode input only changes how they are presented: in 12-hour form with a PM flag, or in 24-hour form.

The time is set with two pulse inputs, one for hours and one for minutes. When the alarm-edit level is high, the same two pulses adjust a stored alarm time instead, and the display shows that alarm time. With the alarm enabled, the alarm output rises when the running time reaches the alarm's hour and minute at second zero. It stays high for one minute unless the enable is dropped first. Button inputs are expected to be clean single-cycle pulses.

Top module: `digital_clock`

## Requirements
- R1: After a synchronous reset the time is 00:00:00, the alarm time is 00:00, `alarm_o` is low and digit 0 is selected.
- R2: Seconds advance by one every TICK_DIV clock cycles, and the first advance comes TICK_DIV cycles after reset is released. Second 59 wraps to 0 and carries into the minutes. Minute 59 wraps and carries into the hours, and 23:59:59 becomes 00:00:00.
- R3: A `btn_min` pulse with `alm_edit` low adds one to the minutes, wrapping 59 to 0 with no carry into the hours, and clears the seconds to 0.
- R4: A `btn_hr` pulse with `alm_edit` low adds one to the hours, wrapping 23 to 0, and leaves minutes and seconds unchanged. If a set pulse arrives in the same cycle as a once-per-second advance, the set is applied and that advance is dropped.
- R5: With `mode_12h` high, displayed hour 0 reads 12, hours 13 to 23 read 1 to 11, and hours 1 to 12 read unchanged. With `mode_12h` low the hour is shown as counted (0 to 23).
- R6: `pm_o` is high exactly when the hour being displayed is 12 to 23 in internal form. This holds in either mode.
- R7: While `alm_edit` is high, the set pulses change the alarm hour and minute with the same wrapping as R3 and R4, and they leave the running time untouched. The display shows the alarm as HH:MM:00.
- R8: With `alm_en` high, `alarm_o` rises one clock after the running time equals alarm hour, alarm minute, second 0.
- R9: Once raised, `alarm_o` stays high through 60 second advances and falls on the 60th. It also falls on the clock after `alm_en` goes low.
- R10: Exactly one bit of `dig_sel_o` is high at any time. The selected digit moves 0,1,2,3,4,5,0,... every SCAN_DIV cycles. Digit 0 is the hours tens digit and digit 5 is the seconds ones digit, so the order is hours tens, hours ones, minutes tens, minutes ones, seconds tens, seconds ones.
- R11: `seg_o` carries the selected digit's pattern in the same cycle, active high, with bit 6 = segment a down to bit 0 = segment g. The codes are 0:7E 1:30 2:6D 3:79 4:33 5:5B 6:5F 7:70 8:7F 9:7B (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_hr | input | 1 | Single-cycle pulse: advance hours (time or alarm) |
| btn_min | input | 1 | Single-cycle pulse: advance minutes (time or alarm) |
| alm_edit | input | 1 | Level: set pulses and display address the alarm |
| alm_en | input | 1 | Level: alarm armed |
| mode_12h | input | 1 | Level: 12-hour display when high |
| seg_o | output | 7 | Segment pattern, bit 6 = a ... bit 0 = g |
| dig_sel_o | output | 6 | One-hot digit select, bit 0 = hours tens |
| pm_o | output | 1 | Displayed hour is in the afternoon half |
| alarm_o | output | 1 | Alarm active |

## Verification
On every cycle, the assertions check the following:
- the digit select is one-hot;
- the counters stay inside their ranges;
- an hour set pulse at 23 wraps the hour to 0;
- a minute set pulse clears the seconds;
- the alarm only rises after a matching time with the enable high;
- the alarm falls once the enable drops.

Only the bench's scenarios can show the rest:
- the full carry chain at midnight;
- the 12-hour mapping of hours 0, 12 and 13;
- that editing the alarm leaves the running time alone;
- that the alarm lasts exactly 60 seconds.

The bench shows these by reading whole scanned frames off the segment bus.

// File: rtl/digital_clock.sv
module digital_clock #(
  parameter int TICK_DIV = 50_000_000,
  parameter int SCAN_DIV = 50_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_hr,
  input  logic       btn_min,
  input  logic       alm_edit,
  input  logic       alm_en,
  input  logic       mode_12h,
  output logic [6:0] seg_o,
  output logic [5:0] dig_sel_o,
  output logic       pm_o,
  output logic       alarm_o
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);
  localparam logic [SW-1:0] SLAST = SW'(SCAN_DIV - 1);

  logic [TW-1:0] div_q;
  logic [SW-1:0] sdiv_q;
  logic [2:0]    idx_q;
  logic [4:0]    hr_q, ahr_q;
  logic [5:0]    mn_q, sc_q, amn_q, acnt_q;
  logic          alarm_q;

  wire tick    = (div_q == TLAST);
  wire step    = (sdiv_q == SLAST);
  wire set_hr  = btn_hr & ~alm_edit;
  wire set_min = btn_min & ~alm_edit;
  wire hit     = (hr_q == ahr_q) && (mn_q == amn_q) && (sc_q == 6'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sdiv_q <= '0;
      idx_q  <= '0;
    end else begin
      div_q  <= tick ? '0 : div_q + 1'b1;
      sdiv_q <= step ? '0 : sdiv_q + 1'b1;
      if (step) idx_q <= (idx_q == 3'd5) ? 3'd0 : idx_q + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_q <= '0; mn_q <= '0; sc_q <= '0;
      ahr_q <= '0; amn_q <= '0;
    end else begin
      if (alm_edit && btn_hr)  ahr_q <= (ahr_q == 5'd23) ? 5'd0 : ahr_q + 5'd1;
      if (alm_edit && btn_min) amn_q <= (amn_q == 6'd59) ? 6'd0 : amn_q + 6'd1;
      if (set_hr || set_min) begin
        if (set_hr) hr_q <= (hr_q == 5'd23) ? 5'd0 : hr_q + 5'd1;
        if (set_min) begin
          mn_q <= (mn_q == 6'd59) ? 6'd0 : mn_q + 6'd1;
          sc_q <= '0;
        end
      end else if (tick) begin
        if (sc_q == 6'd59) begin
          sc_q <= '0;
          if (mn_q == 6'd59) begin
            mn_q <= '0;
            hr_q <= (hr_q == 5'd23) ? 5'd0 : hr_q + 5'd1;
          end else begin
            mn_q <= mn_q + 6'd1;
          end
        end else begin
          sc_q <= sc_q + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !alm_en) begin
      alarm_q <= 1'b0;
      acnt_q  <= '0;
    end else if (!alarm_q) begin
      alarm_q <= hit;
      acnt_q  <= '0;
    end else if (tick) begin
      if (acnt_q == 6'd59) alarm_q <= 1'b0;
      else acnt_q <= acnt_q + 6'd1;
    end
  end

  wire [4:0] src_hr = alm_edit ? ahr_q : hr_q;
  wire [5:0] src_mn = alm_edit ? amn_q : mn_q;
  wire [5:0] src_sc = alm_edit ? 6'd0  : sc_q;
  wire [4:0] show_hr = !mode_12h          ? src_hr :
                       (src_hr == 5'd0)   ? 5'd12 :
                       (src_hr > 5'd12)   ? src_hr - 5'd12 : src_hr;

  logic [3:0] nib;
  always_comb begin
    case (idx_q)
      3'd0:    nib = 4'(show_hr / 5'd10);
      3'd1:    nib = 4'(show_hr % 5'd10);
      3'd2:    nib = 4'(src_mn / 6'd10);
      3'd3:    nib = 4'(src_mn % 6'd10);
      3'd4:    nib = 4'(src_sc / 6'd10);
      default: nib = 4'(src_sc % 6'd10);
    endcase
  end

  always_comb begin
    case (nib)
      4'd0:    seg_o = 7'h7E;
      4'd1:    seg_o = 7'h30;
      4'd2:    seg_o = 7'h6D;
      4'd3:    seg_o = 7'h79;
      4'd4:    seg_o = 7'h33;
      4'd5:    seg_o = 7'h5B;
      4'd6:    seg_o = 7'h5F;
      4'd7:    seg_o = 7'h70;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h7B;
      default: seg_o = 7'h00;
    endcase
  end

  assign dig_sel_o = 6'b000001 << idx_q;
  assign pm_o      = (src_hr >= 5'd12);
  assign alarm_o   = alarm_q;
endmodule

// File: rtl/digital_clock_chk.sv
module digital_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       btn_hr,
  input logic       btn_min,
  input logic       alm_edit,
  input logic       alm_en,
  input logic [5:0] dig_sel_o,
  input logic       alarm_o,
  input logic [4:0] hr_q,
  input logic [5:0] mn_q,
  input logic [5:0] sc_q,
  input logic [4:0] ahr_q,
  input logic [5:0] amn_q
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_sel_o) == 1);                                          // R10
  AST_TIME_RANGE: assert property (@(posedge clk) disable iff (rst)
    hr_q < 5'd24 && mn_q < 6'd60 && sc_q < 6'd60);                        // R2
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (btn_hr && !alm_edit && hr_q == 5'd23) |=> hr_q == 5'd0);             // R4
  AST_MIN_CLEARS_SEC: assert property (@(posedge clk) disable iff (rst)
    (btn_min && !alm_edit) |=> sc_q == 6'd0);                             // R3
  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_o) |-> $past(alm_en && hr_q == ahr_q && mn_q == amn_q && sc_q == 6'd0)); // R8
  AST_ALARM_DISARM: assert property (@(posedge clk) disable iff (rst)
    !alm_en |=> !alarm_o);                                                // R9
endmodule

bind digital_clock digital_clock_chk chk_i (
  .clk(clk), .rst(rst), .btn_hr(btn_hr), .btn_min(btn_min),
  .alm_edit(alm_edit), .alm_en(alm_en), .dig_sel_o(dig_sel_o),
  .alarm_o(alarm_o), .hr_q(hr_q), .mn_q(mn_q), .sc_q(sc_q),
  .ahr_q(ahr_q), .amn_q(amn_q)
);

// File: tb/digital_clock_tb_top.sv
`timescale 1ns/1ps
module digital_clock_tb_top;
  localparam int TD = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_hr = 0, btn_min = 0, alm_edit = 0, alm_en = 0, mode_12h = 0;
  logic [6:0] seg;
  logic [5:0] dig_sel;
  logic pm, alarm;

  always #5 clk = ~clk;

  digital_clock #(.TICK_DIV(TD), .SCAN_DIV(1)) dut_i (
    .clk(clk), .rst(rst), .btn_hr(btn_hr), .btn_min(btn_min),
    .alm_edit(alm_edit), .alm_en(alm_en), .mode_12h(mode_12h),
    .seg_o(seg), .dig_sel_o(dig_sel), .pm_o(pm), .alarm_o(alarm)
  );

  typedef struct packed {
    logic [23:0] digs;
    logic        pm;
    logic        alm;
    logic [7:0]  req;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  function automatic logic [3:0] seg2dig(input logic [6:0] s);
    case (s)
      7'h7E: return 4'd0;  7'h30: return 4'd1;  7'h6D: return 4'd2;
      7'h79: return 4'd3;  7'h33: return 4'd4;  7'h5B: return 4'd5;
      7'h5F: return 4'd6;  7'h70: return 4'd7;  7'h7F: return 4'd8;
      7'h7B: return 4'd9;  default: return 4'hF;
    endcase
  endfunction

  task automatic check(input bit ok, input int req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_disp(input int h, input int m, input int s, input bit p, input bit a, input int req);
    exp_t e;
    e.digs = {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
    e.pm = p; e.alm = a; e.req = 8'(req);
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      logic [23:0] got;
      logic [5:0] seen;
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q[0];
      got = '0; seen = '0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if ($countones(dig_sel) != 1) check(0, 10, "digit select not one-hot", dig_sel, 0);
        for (int i = 0; i < 6; i++)
          if (dig_sel[i]) begin
            got[23 - 4 * i -: 4] = seg2dig(seg);
            seen[i] = 1'b1;
          end
      end
      check(seen == 6'h3F, 10, "digits visited in one scan", seen, 6'h3F);
      check(got == e.digs, int'(e.req), "displayed digits", got, e.digs);
      check(pm == e.pm, int'(e.req), "pm", pm, e.pm);
      check(alarm == e.alm, int'(e.req), "alarm", alarm, e.alm);
      void'(exp_q.pop_front());
    end
  end

  task automatic sync_sec(input int n);
    repeat (n) begin
      do @(negedge clk); while (cyc % TD != 0);
    end
  endtask

  task automatic press_hr(input int n);
    repeat (n) begin btn_hr = 1; @(negedge clk); btn_hr = 0; @(negedge clk); end
  endtask

  task automatic press_min(input int n);
    repeat (n) begin btn_min = 1; @(negedge clk); btn_min = 0; @(negedge clk); end
  endtask

  bit done = 0;
  initial begin : watchdog
    #(190_000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(dig_sel == 6'b000001, 1, "reset digit select", dig_sel, 1);       // R1
    rst = 0;
    expect_disp(0, 0, 0, 0, 0, 1);                                            // R1 reset time, R11 codes
    sync_sec(1);
    expect_disp(0, 0, 1, 0, 0, 2);                                            // R2 first advance
    press_hr(1);
    expect_disp(1, 0, 1, 0, 0, 4);                                            // R4 min/sec untouched
    press_min(60);
    expect_disp(1, 0, 0, 0, 0, 3);                                            // R3 wrap, no carry, sec cleared
    press_hr(12);
    expect_disp(13, 0, 0, 1, 0, 6);                                           // R6 pm in 24h
    mode_12h = 1;
    expect_disp(1, 0, 0, 1, 0, 5);                                            // R5 13 -> 1
    sync_sec(1);
    press_min(60);
    press_hr(11);
    expect_disp(12, 0, 0, 0, 0, 5);                                           // R5 0 -> 12, R4 23->0 wrap
    press_hr(12);
    expect_disp(12, 0, 0, 1, 0, 6);                                           // R6 noon is pm
    mode_12h = 0;
    expect_disp(12, 0, 0, 1, 0, 5);
    sync_sec(1);
    press_min(59);
    press_hr(11);
    expect_disp(23, 59, 0, 1, 0, 3);
    sync_sec(59);
    expect_disp(23, 59, 59, 1, 0, 2);
    sync_sec(1);
    expect_disp(0, 0, 0, 0, 0, 2);                                            // R2 midnight carry
    mode_12h = 1;
    expect_disp(12, 0, 0, 0, 0, 5);
    mode_12h = 0;
    alm_edit = 1;
    press_min(2);
    expect_disp(0, 2, 0, 0, 0, 7);                                            // R7 alarm shown
    alm_edit = 0;
    expect_disp(0, 0, 0, 0, 0, 7);                                            // R7 time untouched
    alm_en = 1;
    sync_sec(119);
    expect_disp(0, 1, 59, 0, 0, 8);
    sync_sec(1);
    expect_disp(0, 2, 0, 0, 1, 8);                                            // R8 rise on match
    sync_sec(59);
    expect_disp(0, 2, 59, 0, 1, 9);                                           // R9 still high
    sync_sec(1);
    expect_disp(0, 3, 0, 0, 0, 9);                                            // R9 falls after 60 s
    alm_en = 0;
    alm_edit = 1;
    press_min(2);
    alm_edit = 0;
    alm_en = 1;
    sync_sec(59);
    expect_disp(0, 3, 59, 0, 0, 8);
    sync_sec(1);
    expect_disp(0, 4, 0, 0, 1, 8);
    alm_en = 0;
    expect_disp(0, 4, 0, 0, 0, 9);                                            // R9 disarm drops alarm
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule